// File: doc/BRIEF.md
# Interrupt Request Capture Stage

This block turns eight raw interrupt lines into an 8-bit pending-request vector for a downstream priority controller. Each line is sampled once per clock. A software-written trigger-select register sets each line to one of two modes. In level mode the pending bit follows the line. In edge mode the pending bit is latched on a low-to-high transition and held until the controller acknowledges it.

Each line keeps a remembered-level state machine with two states:
- `LVL_LOW`: the last sample was low.
- `LVL_HIGH`: the last sample was high.

The transitions are:
- `LVL_LOW -> LVL_HIGH` (rise): the input is sampled high. For an edge-mode line this is the only event that sets the request.
- `LVL_HIGH -> LVL_LOW` (fall): the input is sampled low.
- `LVL_LOW -> LVL_LOW` (stay low) and `LVL_HIGH -> LVL_HIGH` (stay high): the input keeps its level.

An acknowledge clear from the controller drops a request bit but never touches the remembered level. A line still held high after acknowledge therefore does not raise a second request.

Writes to the trigger-select register pass through a fixed per-instance capability mask. A line whose mask bit is zero stays in edge mode whatever software writes. Typical masks are 0xF8 for a primary instance and 0xDE for a secondary one. A synchronous reset returns every line to edge mode, `LVL_LOW` and no pending request. The capability mask is a parameter and is not affected by reset.

Top module: `irq_capture`

## Requirements
- R1: A line whose trigger-select bit is 1 (level mode) has its request bit equal to the input sampled at the previous clock edge, set when high and cleared when low.
- R2: A line whose trigger-select bit is 0 (edge mode) sets its request bit only when it is sampled high while its state is `LVL_LOW`. A line held high does not set the request again.
- R3: In edge mode a low sample moves the line to `LVL_LOW` and leaves a pending request bit set.
- R4: A write of `mode_wr_data` with `mode_wr_en` high stores `mode_wr_data & CAP_MASK`, and `mode_rd_data` returns the stored value from the next cycle on. The default CAP_MASK is 0xF8.
- R5: A line whose CAP_MASK bit is 0 behaves as edge mode even after a write of all ones.
- R6: Acknowledge clear bit i (one-hot, at most one bit high) clears request bit i at the next edge. The remembered level is not changed, so an edge-mode line still held high does not re-request.
- R7: When an edge-mode set and an acknowledge clear hit the same bit in the same cycle, the request bit ends set.
- R8: Reset (synchronous, active high) clears the request bits, the remembered levels and the trigger-select register. An edge-mode input already high at the first sample after reset therefore sets its request.
- R9: A trigger-select write takes effect from the next clock edge. The edge that stores the write still uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset / reinitialisation |
| irq_in | input | 8 | Raw interrupt lines |
| ack_clr | input | 8 | One-hot acknowledge clear per request bit |
| mode_wr_en | input | 1 | Trigger-select write strobe |
| mode_wr_data | input | 8 | Trigger-select write value (1 = level, 0 = edge) |
| mode_rd_data | output | 8 | Stored trigger-select value |
| req_out | output | 8 | Pending request vector |

## Verification
A wrong remembered-level state never shows while the line is stable. It shows at the first edge-mode sample where the input is high after an acknowledge, or first high after reset. There it produces a missing or duplicate request bit one clock later. A wrong mode bit shows at `mode_rd_data` one cycle after the write. It also shows at `req_out` on the first low sample of a pending line, where a level line clears and an edge line holds. The reference model is compared with both outputs on every clock, so any divergence is reported within one cycle of the stimulus that exposes it.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;
    // Remembered level of one input line.
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } line_state_e;
endpackage

// File: rtl/irqcap_mode_reg.sv
module irqcap_mode_reg #(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] CAP_MASK = 8'hF8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q <= wr_data & CAP_MASK;
        end
    end

    // R4: stored value is the written value filtered by the capability mask
    p_mode_masked_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mode_q == ($past(wr_data) & CAP_MASK));

    // R8: reset leaves the register cleared
    p_mode_reset_r8: assert property (@(posedge clk)
        rst |=> mode_q == '0);
endmodule

// File: rtl/irqcap_line.sv
module irqcap_line
    import irqcap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_level,
    input  logic irq,
    input  logic ack,
    output logic req
);
    line_state_e state_q, state_d;
    logic        req_q, req_d;
    logic        rise;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LVL_LOW;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= req_d;
        end
    end

    // next state and request
    always_comb begin
        rise    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            LVL_LOW: begin
                if (irq) begin
                    state_d = LVL_HIGH;
                    rise    = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!irq) begin
                    state_d = LVL_LOW;
                end
            end
        endcase
        if (trig_level) begin
            req_d = irq;
        end else begin
            req_d = rise | (req_q & ~ack);
        end
    end

    assign req = req_q;

    // R1: level mode follows the sampled input
    p_level_follow_r1: assert property (@(posedge clk) disable iff (rst)
        trig_level |=> req == $past(irq));

    // R2/R7: edge-mode rise sets the request even under acknowledge
    p_edge_set_r2: assert property (@(posedge clk) disable iff (rst)
        (!trig_level && irq && state_q == LVL_LOW) |=> req);

    // R3: low input in edge mode keeps a pending request without acknowledge
    p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!trig_level && !irq && !ack && req) |=> req);

    // R6: acknowledge does not disturb the remembered level
    p_ack_keeps_level_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && irq) |=> state_q == LVL_HIGH);
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int                NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] CAP_MASK = 8'hF8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] ack_clr,
    input  logic                 mode_wr_en,
    input  logic [NUM_LINES-1:0] mode_wr_data,
    output logic [NUM_LINES-1:0] mode_rd_data,
    output logic [NUM_LINES-1:0] req_out
);
    logic [NUM_LINES-1:0] mode_q;

    irqcap_mode_reg #(
        .WIDTH    (NUM_LINES),
        .CAP_MASK (CAP_MASK)
    ) u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .mode_q  (mode_q)
    );

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            irqcap_line u_line (
                .clk        (clk),
                .rst        (rst),
                .trig_level (mode_q[i]),
                .irq        (irq_in[i]),
                .ack        (ack_clr[i]),
                .req        (req_out[i])
            );
        end
    endgenerate

    assign mode_rd_data = mode_q;

    // R6: acknowledge is one-hot or idle
    p_ack_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_clr));

    // R8: reset clears every pending request
    p_req_reset_r8: assert property (@(posedge clk)
        rst |=> req_out == '0);
endmodule

// File: tb/irq_capture_test.sv
module irq_capture_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in, ack_clr, mode_wr_data;
    logic       mode_wr_en;
    logic [7:0] mode_rd_data, req_out;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    string tag = "R8";

    // behavioural reference state
    logic [7:0] m_mode, m_req, m_lvl;

    always #5 clk = ~clk;

    irq_capture uut (
        .clk          (clk),
        .rst          (rst),
        .irq_in       (irq_in),
        .ack_clr      (ack_clr),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .mode_rd_data (mode_rd_data),
        .req_out      (req_out)
    );

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", t, act, exp, $time);
        end
    endtask

    // one clock: model update at the edge, compare away from it
    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_mode = 8'h00; m_req = 8'h00; m_lvl = 8'h00;
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (m_mode[i]) begin
                    m_req[i] = irq_in[i];
                end else begin
                    m_req[i] = (irq_in[i] && !m_lvl[i]) || (m_req[i] && !ack_clr[i]);
                end
                m_lvl[i] = irq_in[i];
            end
            if (mode_wr_en) m_mode = mode_wr_data & 8'hF8;
        end
        @(negedge clk);
        chk({tag, " req_out"}, req_out, m_req);
        chk({tag, " mode_rd_data"}, mode_rd_data, m_mode);
        mode_wr_en = 1'b0;
        ack_clr    = 8'h00;
    endtask

    task automatic wr_mode(input logic [7:0] v);
        mode_wr_en = 1'b1; mode_wr_data = v;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_in = 8'h00; ack_clr = 8'h00;
        mode_wr_en = 1'b0; mode_wr_data = 8'h00;
        m_mode = 8'h00; m_req = 8'h00; m_lvl = 8'h00;
        @(negedge clk);
        step(); step();
        // R8: reset state
        chk("R8 reset req", req_out, 8'h00);
        chk("R8 reset mode", mode_rd_data, 8'h00);
        rst = 1'b0;

        // R4: masked writes
        tag = "R4";
        wr_mode(8'hFF);
        chk("R4 write FF", mode_rd_data, 8'hF8);
        wr_mode(8'h0F);
        chk("R4 write 0F", mode_rd_data, 8'h08);
        wr_mode(8'hFF);

        // R1: level line 4 follows input
        tag = "R1";
        irq_in[4] = 1'b1; step();
        chk("R1 level high", req_out & 8'h10, 8'h10);
        irq_in[4] = 1'b0; step();
        chk("R1 level low", req_out & 8'h10, 8'h00);

        // R2/R6: edge line 0 (forced edge by mask, also R5)
        tag = "R2";
        irq_in[0] = 1'b1; step();
        chk("R2 edge rise", req_out & 8'h01, 8'h01);
        step();
        chk("R2 held high", req_out & 8'h01, 8'h01);
        tag = "R6";
        ack_clr = 8'h01; step();
        chk("R6 ack clears", req_out & 8'h01, 8'h00);
        step();
        chk("R6 no re-request while high", req_out & 8'h01, 8'h00);
        tag = "R2";
        irq_in[0] = 1'b0; step();
        irq_in[0] = 1'b1; step();
        chk("R2 second rise", req_out & 8'h01, 8'h01);
        // R3: low keeps pending
        tag = "R3";
        irq_in[0] = 1'b0; step(); step();
        chk("R3 pending kept", req_out & 8'h01, 8'h01);

        // R5: line 1 stays edge despite all-ones write
        tag = "R5";
        irq_in[1] = 1'b1; step();
        irq_in[1] = 1'b0; step();
        chk("R5 forced edge holds", req_out & 8'h02, 8'h02);

        // R7: set and ack together on line 2
        tag = "R7";
        irq_in[2] = 1'b1; ack_clr = 8'h04; step();
        chk("R7 set wins", req_out & 8'h04, 8'h04);

        // R9: write to edge, same edge still level for line 5
        tag = "R9";
        irq_in[5] = 1'b1; mode_wr_en = 1'b1; mode_wr_data = 8'h00; step();
        chk("R9 old mode used", req_out & 8'h20, 8'h20);
        irq_in[5] = 1'b0; step();
        chk("R9 new edge mode holds", req_out & 8'h20, 8'h20);

        // R8: reset with pending state, input held high afterwards
        tag = "R8";
        irq_in = 8'h01; rst = 1'b1; step();
        chk("R8 reset clears pending", req_out, 8'h00);
        rst = 1'b0; step();
        chk("R8 edge after reset", req_out & 8'h01, 8'h01);

        // mixed traffic against the model
        tag = "R1 R2 R3 R6 R7";
        for (int n = 0; n < 400; n++) begin
            irq_in = 8'($urandom);
            if ($urandom % 3 == 0) ack_clr = 8'(1 << ($urandom % 8));
            if ($urandom % 16 == 0) begin
                mode_wr_en = 1'b1; mode_wr_data = 8'($urandom);
            end
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule